// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

This master-side sequencer waits for a serial memory to finish its internal write cycle. It starts as soon as the host has closed a write with STOP. Each attempt sends a START and then the device address byte with the read/write bit cleared, and then it reads the acknowledge bit returned in the ninth clock. While the device is busy it does not acknowledge. The sequencer then closes the attempt with STOP and tries again. The busy time is typically a few milliseconds, so the number of attempts is bounded. An acknowledge means the write is finished.

What happens after the acknowledge depends on the next host operation. If the next operation is a write, the sequencer sends the word address byte and hands over with the bus still held, so the host can go on sending data. Otherwise it sends STOP and hands over with the bus released. A programmable limit on the number of refused attempts ends the polling with a timeout flag.

The bit-level bus timing is not part of this block. It drives a byte-level bus engine through one-cycle commands, and the engine answers with a done pulse that carries the received acknowledge bit.

Top module: `ackpoll_seq`

## Requirements
- R1: While rst_ni is low, every output is zero: busy_o, done_o, timeout_o, hold_bus_o, cmd_valid_o, cmd_op_o, cmd_data_o and retry_cnt_o.
- R2: start_i is accepted only while busy_o is low. The cycle after acceptance shows busy_o high and a START command. A start_i pulse while busy_o is high has no effect.
- R3: When the START command completes, the next command is a byte write whose data is the device address in bits 7..1 and zero in bit 0 (the write direction). The address is captured when start_i is accepted.
- R4: If the address byte completes without acknowledge and retry_cnt_o is below the limit, retry_cnt_o goes up by one. A STOP command follows, and after that a new START.
- R5: If the address byte is acknowledged and next-write was set at start, a byte write of the captured word address follows and no STOP is sent. The run then ends with hold_bus_o = 1.
- R6: If the address byte is acknowledged and next-write was clear, a STOP command follows. The run then ends with hold_bus_o = 0 and timeout_o = 0.
- R7: If the address byte is refused while retry_cnt_o equals the captured limit, a STOP command follows and the run ends with timeout_o = 1. retry_cnt_o then stays at the limit, so it never exceeds the limit.
- R8: Each command is a one-cycle cmd_valid_o pulse. The next command is issued only in the cycle after eng_done_i answers the current one. An eng_done_i pulse that arrives while no command is outstanding is ignored.
- R9: Each run ends with a one-cycle done_o pulse, and busy_o is low in the following cycle. timeout_o, hold_bus_o and retry_cnt_o keep their values until the next accepted start_i, which clears them.
- R10: Command codes on cmd_op_o are 1 for START, 2 for WRITE and 3 for STOP. cmd_op_o and cmd_data_o are 0 whenever cmd_valid_o is low, and cmd_data_o is 0 for START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (one-cycle pulse) |
| dev_addr_i | input | DEV_W | 7-bit device address |
| next_write_i | input | 1 | The next host operation is a write |
| word_addr_i | input | DEV_W+1 | Word address sent when next_write_i is set |
| max_retry_i | input | RETRY_W | Limit on refused attempts before timeout |
| eng_done_i | input | 1 | Bus engine finished the outstanding command |
| eng_ack_i | input | 1 | Acknowledge bit received, valid with eng_done_i |
| cmd_valid_o | output | 1 | Command strobe to the bus engine |
| cmd_op_o | output | 2 | Command code |
| cmd_data_o | output | DEV_W+1 | Byte to send for WRITE |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Run finished (one cycle) |
| hold_bus_o | output | 1 | Run ended without STOP, bus still held |
| timeout_o | output | 1 | Run ended because the retry limit was reached |
| retry_cnt_o | output | RETRY_W | Refused attempts in the current or last run |

## Verification
A reference model in the bench follows each run cycle by cycle. It is driven by a bus engine model that refuses a chosen number of address bytes before it acknowledges.

The runs cover these cases:
- An immediate acknowledge with and without next-write. These tell apart the word-address path and the STOP path.
- Several refusals under a generous limit. This shows the retry loop with a closing STOP on every attempt.
- Refusals beyond the limit, including a limit of zero. These show that the timeout fires at exactly the limit and not one attempt later.
- Different engine latencies. These show that every step waits for the engine's done and not for a fixed number of cycles.
- A start pulse in the middle of a run and a stray done pulse while idle. These show that both are ignored.

// File: rtl/ackpoll_pkg.sv
package ackpoll_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_WRITE = 2'd2,
    OP_STOP  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_START_W,
    ST_ADDR,
    ST_ADDR_W,
    ST_RSTOP,
    ST_RSTOP_W,
    ST_WADDR,
    ST_WADDR_W,
    ST_FSTOP,
    ST_FSTOP_W,
    ST_DONE
  } st_e;

endpackage

// File: rtl/ackpoll_req.sv
module ackpoll_req #(
  parameter int DEV_W   = 7,
  parameter int RETRY_W = 8,
  localparam int BYTE_W = DEV_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DEV_W-1:0]   dev_i,
  input  logic [BYTE_W-1:0]  waddr_i,
  input  logic               nw_i,
  input  logic [RETRY_W-1:0] max_i,
  output logic [DEV_W-1:0]   dev_o,
  output logic [BYTE_W-1:0]  waddr_o,
  output logic               nw_o,
  output logic [RETRY_W-1:0] max_o
);

  // request fields are frozen for the whole run
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_o   <= '0;
      waddr_o <= '0;
      nw_o    <= 1'b0;
      max_o   <= '0;
    end else if (load_i) begin
      dev_o   <= dev_i;
      waddr_o <= waddr_i;
      nw_o    <= nw_i;
      max_o   <= max_i;
    end
  end

endmodule

// File: rtl/ackpoll_retry.sv
module ackpoll_retry #(
  parameter int RETRY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               inc_i,
  input  logic [RETRY_W-1:0] max_i,
  output logic [RETRY_W-1:0] cnt_o,
  output logic               at_max_o
);

  localparam logic [RETRY_W-1:0] ONE = RETRY_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (inc_i && !at_max_o) begin
      cnt_o <= cnt_o + ONE;
    end
  end

  assign at_max_o = (cnt_o == max_i);

endmodule

// File: rtl/ackpoll_cmd_enc.sv
module ackpoll_cmd_enc
  import ackpoll_pkg::*;
#(
  parameter int DEV_W = 7,
  localparam int BYTE_W = DEV_W + 1
) (
  input  st_e               state_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic [BYTE_W-1:0] waddr_i,
  output logic              valid_o,
  output op_e               op_o,
  output logic [BYTE_W-1:0] data_o
);

  always_comb begin
    valid_o = 1'b1;
    op_o    = OP_NONE;
    data_o  = '0;
    unique case (state_i)
      ST_START: op_o = OP_START;
      ST_ADDR: begin
        op_o   = OP_WRITE;
        data_o = {dev_i, 1'b0};  // write direction
      end
      ST_WADDR: begin
        op_o   = OP_WRITE;
        data_o = waddr_i;
      end
      ST_RSTOP, ST_FSTOP: op_o = OP_STOP;
      default: valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ackpoll_fsm.sv
module ackpoll_fsm
  import ackpoll_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  input  logic ack_i,
  input  logic nw_i,
  input  logic at_max_i,
  output st_e  state_o,
  output logic load_o,
  output logic inc_o,
  output logic timeout_o,
  output logic hold_o
);

  st_e  state_d;
  logic to_pend_q, to_pend_d;
  logic timeout_d, hold_d;

  assign load_o = (state_o == ST_IDLE) && start_i;
  assign inc_o  = (state_o == ST_ADDR_W) && done_i && !ack_i && !at_max_i;

  always_comb begin
    state_d   = state_o;
    to_pend_d = to_pend_q;
    timeout_d = timeout_o;
    hold_d    = hold_o;
    unique case (state_o)
      ST_IDLE: if (start_i) begin
        state_d   = ST_START;
        to_pend_d = 1'b0;
        timeout_d = 1'b0;
        hold_d    = 1'b0;
      end
      ST_START:   state_d = ST_START_W;
      ST_START_W: if (done_i) state_d = ST_ADDR;
      ST_ADDR:    state_d = ST_ADDR_W;
      ST_ADDR_W: if (done_i) begin
        if (ack_i) begin
          state_d = nw_i ? ST_WADDR : ST_FSTOP;
        end else if (at_max_i) begin
          state_d   = ST_FSTOP;
          to_pend_d = 1'b1;
        end else begin
          state_d = ST_RSTOP;
        end
      end
      ST_RSTOP:   state_d = ST_RSTOP_W;
      ST_RSTOP_W: if (done_i) state_d = ST_START;
      ST_WADDR:   state_d = ST_WADDR_W;
      ST_WADDR_W: if (done_i) begin
        state_d = ST_DONE;
        hold_d  = 1'b1;
      end
      ST_FSTOP:   state_d = ST_FSTOP_W;
      ST_FSTOP_W: if (done_i) begin
        state_d   = ST_DONE;
        timeout_d = to_pend_q;
      end
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o   <= ST_IDLE;
      to_pend_q <= 1'b0;
      timeout_o <= 1'b0;
      hold_o    <= 1'b0;
    end else begin
      state_o   <= state_d;
      to_pend_q <= to_pend_d;
      timeout_o <= timeout_d;
      hold_o    <= hold_d;
    end
  end

endmodule

// File: rtl/ackpoll_seq.sv
module ackpoll_seq
  import ackpoll_pkg::*;
#(
  parameter int DEV_W   = 7,
  parameter int RETRY_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [DEV_W-1:0]   dev_addr_i,
  input  logic               next_write_i,
  input  logic [DEV_W:0]     word_addr_i,
  input  logic [RETRY_W-1:0] max_retry_i,
  input  logic               eng_done_i,
  input  logic               eng_ack_i,
  output logic               cmd_valid_o,
  output logic [1:0]         cmd_op_o,
  output logic [DEV_W:0]     cmd_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               hold_bus_o,
  output logic               timeout_o,
  output logic [RETRY_W-1:0] retry_cnt_o
);

  localparam int BYTE_W = DEV_W + 1;

  st_e                state;
  logic               load, inc, at_max;
  logic [DEV_W-1:0]   req_dev;
  logic [BYTE_W-1:0]  req_waddr;
  logic               req_nw;
  logic [RETRY_W-1:0] req_max;
  op_e                op;

  ackpoll_req #(.DEV_W(DEV_W), .RETRY_W(RETRY_W)) u_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .dev_i   (dev_addr_i),
    .waddr_i (word_addr_i),
    .nw_i    (next_write_i),
    .max_i   (max_retry_i),
    .dev_o   (req_dev),
    .waddr_o (req_waddr),
    .nw_o    (req_nw),
    .max_o   (req_max)
  );

  ackpoll_retry #(.RETRY_W(RETRY_W)) u_retry (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (load),
    .inc_i    (inc),
    .max_i    (req_max),
    .cnt_o    (retry_cnt_o),
    .at_max_o (at_max)
  );

  ackpoll_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .done_i    (eng_done_i),
    .ack_i     (eng_ack_i),
    .nw_i      (req_nw),
    .at_max_i  (at_max),
    .state_o   (state),
    .load_o    (load),
    .inc_o     (inc),
    .timeout_o (timeout_o),
    .hold_o    (hold_bus_o)
  );

  ackpoll_cmd_enc #(.DEV_W(DEV_W)) u_enc (
    .state_i (state),
    .dev_i   (req_dev),
    .waddr_i (req_waddr),
    .valid_o (cmd_valid_o),
    .op_o    (op),
    .data_o  (cmd_data_o)
  );

  assign cmd_op_o = op;
  assign busy_o   = (state != ST_IDLE);
  assign done_o   = (state == ST_DONE);

endmodule

// File: rtl/ackpoll_seq_chk.sv
module ackpoll_seq_chk #(
  parameter int RETRY_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               timeout_o,
  input logic               cmd_valid_o,
  input logic [1:0]         cmd_op_o,
  input logic [RETRY_W-1:0] retry_cnt_o,
  input logic [RETRY_W-1:0] max_q
);

  p_cmd_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cmd_valid_o && !done_o));

  p_start_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (cmd_valid_o && cmd_op_o == 2'd1));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  p_retry_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (retry_cnt_o <= max_q));

  p_retry_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (retry_cnt_o == $past(retry_cnt_o) || retry_cnt_o == $past(retry_cnt_o) + 1'b1));

  p_op_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o == (cmd_op_o != 2'd0)));

  p_timeout_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> done_o);

endmodule

bind ackpoll_seq ackpoll_seq_chk #(.RETRY_W(RETRY_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_op_o    (cmd_op_o),
  .retry_cnt_o (retry_cnt_o),
  .max_q       (req_max)
);

// File: tb/ackpoll_seq_test.sv
module ackpoll_seq_test;
  localparam int DEV_W = 7;
  localparam int RW    = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DEV_W-1:0] dev = '0;
  logic          nw = 1'b0;
  logic [DEV_W:0] waddr = '0;
  logic [RW-1:0] maxr = '0;
  logic          done_i = 1'b0, ack_i = 1'b0;
  logic          cmd_valid, busy, done, hold, tout;
  logic [1:0]    cmd_op;
  logic [DEV_W:0] cmd_data;
  logic [RW-1:0] retry;

  always #10 clk = ~clk;

  ackpoll_seq #(.DEV_W(DEV_W), .RETRY_W(RW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dev_addr_i(dev),
    .next_write_i(nw), .word_addr_i(waddr), .max_retry_i(maxr),
    .eng_done_i(done_i), .eng_ack_i(ack_i), .cmd_valid_o(cmd_valid),
    .cmd_op_o(cmd_op), .cmd_data_o(cmd_data), .busy_o(busy), .done_o(done),
    .hold_bus_o(hold), .timeout_o(tout), .retry_cnt_o(retry)
  );

  int checks = 0, fails = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- bus engine model ----------------
  int nack_left = 0, lat = 1, cnt = 0;
  bit inj = 1'b0, after_start = 1'b0, pend_ack = 1'b0;

  always @(negedge clk) begin
    if (done_i) begin done_i = 1'b0; ack_i = 1'b0; end
    if (inj) begin done_i = 1'b1; ack_i = 1'b1; inj = 1'b0; end
    else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin done_i = 1'b1; ack_i = pend_ack; end
    end else if (cmd_valid) begin
      pend_ack = 1'b1;
      if (cmd_op == 2'd1) after_start = 1'b1;
      else if (cmd_op == 2'd2 && after_start) begin
        after_start = 1'b0;
        if (nack_left > 0) begin pend_ack = 1'b0; nack_left--; end
      end
      cnt = lat;
    end
  end

  // ---------------- reference model ----------------
  bit e_valid = 0, e_busy = 0, e_done = 0, e_hold = 0, e_to = 0;
  int e_op = 0, e_data = 0, e_retry = 0;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(input int op, input int d);
    e_valid = 1; e_op = op; e_data = d;
    step();
    e_valid = 0; e_op = 0; e_data = 0;
  endtask

  task automatic wait_done(output bit a);
    do step(); while (!done_i);
    a = ack_i;
  endtask

  task automatic run_poll();
    bit a;
    int m_dev = int'(dev), m_wa = int'(waddr), m_mx = int'(maxr);
    bit m_nw = nw;
    e_busy = 1; e_retry = 0; e_to = 0; e_hold = 0;
    forever begin
      issue(1, 0);
      wait_done(a);
      issue(2, m_dev * 2);
      wait_done(a);
      if (a) begin
        if (m_nw) begin issue(2, m_wa); wait_done(a); e_hold = 1; end
        else begin issue(3, 0); wait_done(a); end
        break;
      end else if (e_retry == m_mx) begin
        issue(3, 0); wait_done(a); e_to = 1;
        break;
      end else begin
        e_retry++;
        issue(3, 0); wait_done(a);
      end
    end
    e_done = 1;
    step();
    e_done = 0; e_busy = 0;
  endtask

  initial begin
    @(posedge rst_n);
    forever begin
      step();
      if (start) run_poll();
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "reset outputs", int'({cmd_valid, cmd_op, cmd_data, busy, done, hold, tout, retry}), 0);
    end else begin
      chk("R2", "busy_o", int'(busy), int'(e_busy));
      chk("R9", "done_o", int'(done), int'(e_done));
      chk("R8", "cmd_valid_o", int'(cmd_valid), int'(e_valid));
      chk("R10", "cmd_op_o", int'(cmd_op), e_op);
      chk("R3", "cmd_data_o", int'(cmd_data), e_data);
      chk("R4", "retry_cnt_o", int'(retry), e_retry);
      chk("R7", "timeout_o", int'(tout), int'(e_to));
      chk("R5", "hold_bus_o", int'(hold), int'(e_hold));
    end
  end

  // ---------------- scenarios ----------------
  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic run(input int d, input bit n, input int wa, input int mx, input int nacks,
                     input int l, input bit poke, input bit x_to, input bit x_hold, input int x_retry);
    @(negedge clk);
    nack_left = nacks; lat = l; after_start = 0;
    dev = DEV_W'(d); nw = n; waddr = (DEV_W+1)'(wa); maxr = RW'(mx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      dev = ~dev; start = 1'b1;  // R2: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (x_hold) chk("R5", "hold at done", int'(hold), 1);
    else if (!x_to) chk("R6", "hold/timeout at done", int'({hold, tout}), 0);
    chk("R7", "timeout at done", int'(tout), int'(x_to));
    chk("R4", "retry at done", int'(retry), x_retry);
    @(negedge clk);
    chk("R9", "busy after done", int'(busy), 0);
    repeat (2) @(negedge clk);
    chk("R9", "flags held", int'({hold, tout}), int'({x_hold, x_to}));
    nack_left = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(7'h50, 1, 8'h3c, 5, 0, 1, 0, 0, 1, 0);   // R5 immediate ack, next write
    run(7'h50, 0, 8'h00, 5, 3, 2, 0, 0, 0, 3);   // R4 R6 three refusals
    run(7'h2a, 0, 8'h11, 2, 10, 1, 0, 1, 0, 2);  // R7 limit reached
    run(7'h01, 0, 8'h00, 0, 0, 3, 0, 0, 0, 0);   // R6 limit zero, ack
    run(7'h7f, 1, 8'hff, 0, 1, 1, 0, 1, 0, 0);   // R7 limit zero, refused
    run(7'h33, 1, 8'ha5, 4, 2, 3, 1, 0, 1, 2);   // R2 start while busy, R5
    @(negedge clk); inj = 1'b1;                  // R8 stray done while idle
    repeat (4) @(negedge clk);
    chk("R8", "stray done ignored", int'({busy, cmd_valid}), 0);
    run(7'h44, 0, 8'h00, 3, 3, 2, 0, 0, 0, 3);   // R4 R7 boundary: refusals equal limit
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog act=running exp=finished");
    summary();
    $finish;
  end

endmodule